// File: doc/BRIEF.md
# Signal-Strength Readout Hold

This block keeps a received-signal-strength reading available for software or downstream logic while a receiver listens. An 8-bit two's-complement strength sample, in half-dB steps, arrives with a valid strobe. The readout register follows these samples until a sync pattern is reported. If sync detection is enabled, the reading then stays fixed and so describes the packet that just began. The next entry into receive mode releases it.

In parallel, the block counts received bytes from each receive entry. On the strobe of a chosen byte in the packet (the eighth by default) it records the strength as a status byte, which framing logic appends after the packet. It records the byte only when appending is enabled. A small combinational converter turns the current readout into a signed power figure: it halves the signed value and subtracts a fixed offset.

Top module: `rssi_hold`

## Requirements
- R1: After a synchronous active-low reset, `rd_value` and `snap_value` are 0, and `rd_power` equals minus `PWR_OFFSET` (-72 by default).
- R2: While the readout is not held, a sample with `smp_valid` high appears on `rd_value` after the next clock edge. Without `smp_valid`, `rd_value` keeps its value.
- R3: A `sync_hit` pulse while `sync_en` is 1 (and `rx_enter` is 0) holds the readout from the following cycle. A valid sample in the sync cycle itself is still taken. Later samples are ignored.
- R4: An `rx_enter` pulse releases a held readout, and samples after it are tracked again. A sample in the same cycle as `rx_enter` on a held readout is not taken. If `rx_enter` and `sync_hit` arrive together, `rx_enter` wins and the readout is not held.
- R5: While `sync_en` is 0, `sync_hit` has no effect and the readout keeps tracking.
- R6: With `append_en` high, the `SNAP_BYTE`-th `byte_stb` (8 by default) after reset or `rx_enter` loads `snap_value`. It loads the sample on that cycle if `smp_valid` is high, and otherwise the most recent valid sample. Further strobes in the same packet leave `snap_value` unchanged.
- R7: If `append_en` is 0 on the `SNAP_BYTE`-th strobe, `snap_value` keeps its previous value for the rest of that packet.
- R8: `rx_enter` restarts the byte count, so the next packet captures a new snapshot. A strobe in the same cycle as `rx_enter` is not counted.
- R9: `rd_power` = floor(s/2) - `PWR_OFFSET`. Here s is `rd_value` read as two's complement, so values of 128 or more stand for value-256. `rd_power` follows `rd_value` with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data | input | 8 | Live strength sample, two's complement, half-dB |
| smp_valid | input | 1 | Sample strobe |
| sync_hit | input | 1 | Sync-detected pulse |
| rx_enter | input | 1 | Receive-entry pulse |
| byte_stb | input | 1 | Byte-received strobe |
| sync_en | input | 1 | Sync detection enabled |
| append_en | input | 1 | Status-append enable |
| rd_value | output | 8 | Readout register |
| snap_value | output | 8 | Packet snapshot byte |
| rd_power | output | 9 | Signed power estimate from readout |

## Verification
The bench uses the default parameters: 8-bit samples, a snapshot on the eighth byte and an offset of 72. With these values, one table of 38 vectors covers a full packet and the saturation of the count after capture. The same table covers a second packet whose capture uses a held sample rather than a fresh one. The default 9-bit power width lets the extreme readings 0x7F, 0x80 and 0xFF reach both ends of the converter range, and the bench checks those cases directly.

// File: rtl/rssi_hold_pkg.sv
// Package: shared types for the signal-strength readout hold.
// Assumes: nothing beyond IEEE 1800-2017.
package rssi_hold_pkg;

    // Readout register mode: following samples, or held after sync.
    typedef enum logic {
        RD_TRACK = 1'b0,
        RD_HELD  = 1'b1
    } rd_mode_t;

endpackage

// File: rtl/rssi_readout_reg.sv
// Module: readout register that follows valid samples and holds after sync.
// Assumes: sync_hit and rx_enter are single-cycle pulses; synchronous
// active-low reset; rx_enter has priority over sync_hit.
module rssi_readout_reg
    import rssi_hold_pkg::*;
#(
    parameter int RSSI_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSSI_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic              sync_hit,
    input  logic              rx_enter,
    input  logic              sync_en,
    output logic [RSSI_W-1:0] rd_value,
    output logic              rd_held
);

    rd_mode_t mode_q;
    rd_mode_t mode_d;

    // Next mode: entry releases, an enabled sync holds, otherwise keep.
    always_comb begin
        mode_d = mode_q;
        if (rx_enter)
            mode_d = RD_TRACK;
        else if (sync_hit && sync_en)
            mode_d = RD_HELD;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= RD_TRACK;
        else
            mode_q <= mode_d;
    end

    // Readout register: load valid samples only while tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_value <= '0;
        else if (mode_q == RD_TRACK && smp_valid)
            rd_value <= smp_data;
    end

    assign rd_held = (mode_q == RD_HELD);

    assert_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_held && smp_valid) |=> (rd_value == $past(smp_data)));

    assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_held |=> $stable(rd_value));

    assert_sync_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_hit && sync_en && !rx_enter) |=> rd_held);

    assert_entry_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enter |=> !rd_held);

    assert_no_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_held && !sync_en) |=> !rd_held);

endmodule

// File: rtl/rssi_pkt_snap.sv
// Module: counts received bytes per packet and records the strength on
// the SNAP_BYTE-th strobe when appending is enabled.
// Assumes: rx_enter starts a packet; the count saturates after capture so
// only one snapshot is taken per packet; synchronous active-low reset.
module rssi_pkt_snap #(
    parameter int RSSI_W    = 8,
    parameter int SNAP_BYTE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSSI_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic              rx_enter,
    input  logic              byte_stb,
    input  logic              append_en,
    output logic [RSSI_W-1:0] snap_value
);

    localparam int CNT_W = $clog2(SNAP_BYTE + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SNAP_BYTE);
    localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(SNAP_BYTE - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [RSSI_W-1:0] live_q;
    logic              take;

    // Capture condition: the strobe that completes the chosen byte.
    assign take = byte_stb && !rx_enter && append_en && (cnt_q == CNT_PRE);

    // Most recent valid sample, used when none arrives with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_q <= '0;
        else if (smp_valid)
            live_q <= smp_data;
    end

    // Byte counter: cleared on entry, saturates at SNAP_BYTE.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rx_enter)
            cnt_q <= '0;
        else if (byte_stb && cnt_q != CNT_LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // Snapshot register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_value <= '0;
        else if (take)
            snap_value <= smp_valid ? smp_data : live_q;
    end

    always_comb begin
        assert_cnt_bound_R6: assert (!rst_n || cnt_q <= CNT_LAST);
    end

    assert_snap_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_stb || rx_enter || !append_en) |=> $stable(snap_value));

    assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_LAST && !rx_enter) |=> (cnt_q == CNT_LAST));

    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enter |=> (cnt_q == '0));

endmodule

// File: rtl/rssi_power_conv.sv
// Module: combinational converter from a two's-complement half-dB reading
// to a signed power figure: floor(reading/2) - offset.
// Assumes: PWR_W > RSSI_W so the offset subtraction cannot wrap for
// offsets below 2**(PWR_W-2).
module rssi_power_conv #(
    parameter int RSSI_W     = 8,
    parameter int PWR_W      = 9,
    parameter int PWR_OFFSET = 72
) (
    input  logic [RSSI_W-1:0]       rd_value,
    output logic signed [PWR_W-1:0] rd_power
);

    logic signed [PWR_W-1:0] ext;
    logic signed [PWR_W-1:0] half;

    // Sign-extend, halve with rounding toward minus infinity, remove offset.
    always_comb begin
        ext      = PWR_W'($signed(rd_value));
        half     = ext >>> 1;
        rd_power = half - PWR_W'(PWR_OFFSET);
    end

endmodule

// File: rtl/rssi_hold.sv
// Module: top of the signal-strength readout hold. Joins the readout
// register, the per-packet snapshot and the power converter.
// Assumes: all control inputs are synchronous to clk.
module rssi_hold #(
    parameter int RSSI_W     = 8,
    parameter int SNAP_BYTE  = 8,
    parameter int PWR_W      = 9,
    parameter int PWR_OFFSET = 72
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [RSSI_W-1:0]       smp_data,
    input  logic                    smp_valid,
    input  logic                    sync_hit,
    input  logic                    rx_enter,
    input  logic                    byte_stb,
    input  logic                    sync_en,
    input  logic                    append_en,
    output logic [RSSI_W-1:0]       rd_value,
    output logic [RSSI_W-1:0]       snap_value,
    output logic signed [PWR_W-1:0] rd_power
);

    logic rd_held;

    rssi_readout_reg #(.RSSI_W(RSSI_W)) u_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .sync_hit  (sync_hit),
        .rx_enter  (rx_enter),
        .sync_en   (sync_en),
        .rd_value  (rd_value),
        .rd_held   (rd_held)
    );

    rssi_pkt_snap #(.RSSI_W(RSSI_W), .SNAP_BYTE(SNAP_BYTE)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_data   (smp_data),
        .smp_valid  (smp_valid),
        .rx_enter   (rx_enter),
        .byte_stb   (byte_stb),
        .append_en  (append_en),
        .snap_value (snap_value)
    );

    rssi_power_conv #(.RSSI_W(RSSI_W), .PWR_W(PWR_W), .PWR_OFFSET(PWR_OFFSET)) u_conv (
        .rd_value (rd_value),
        .rd_power (rd_power)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_value == '0 && snap_value == '0));

    assert_held_after_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_held && !rx_enter) |=> rd_held);

endmodule

// File: tb/rssi_hold_test.sv
// Bench: vector table walked by one loop, then directed reset and
// converter corner cases. Drives on the falling edge, checks on the next.
module rssi_hold_test;

    typedef struct packed {
        logic       v;
        logic [7:0] s;
        logic       sy;
        logic       rx;
        logic       b;
        logic       se;
        logic       ap;
        logic [7:0] erd;
        logic [7:0] esn;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VECS [NV] = '{
        // v   s      sy    rx    b     se    ap    rd     snap
        '{1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h10, 8'h00}, // 0  R2
        '{1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20, 8'h00}, // 1  R2
        '{1'b0, 8'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h20, 8'h00}, // 2  R2 no valid
        '{1'b1, 8'h30, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h30, 8'h00}, // 3  R3 sync cycle
        '{1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h30, 8'h00}, // 4  R3 held
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00}, // 5  byte 1
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00}, // 6  byte 2
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00}, // 7  byte 3
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00}, // 8  byte 4
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00}, // 9  byte 5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00}, // 10 byte 6
        '{1'b1, 8'h50, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h00}, // 11 byte 7
        '{1'b1, 8'h60, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h60}, // 12 R6 byte 8
        '{1'b1, 8'h70, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h30, 8'h60}, // 13 R6 byte 9
        '{1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h30, 8'h60}, // 14 R4 entry
        '{1'b1, 8'h90, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h90, 8'h60}, // 15 R4 tracks
        '{1'b1, 8'hA0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA0, 8'h60}, // 16 R4 priority
        '{1'b1, 8'hB0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hB0, 8'h60}, // 17 R4 not held
        '{1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC0, 8'h60}, // 18 R5
        '{1'b1, 8'hC1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC1, 8'h60}, // 19 R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h60}, // 20 R7 byte 1
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h60}, // 21
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h60}, // 22
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h60}, // 23
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h60}, // 24
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h60}, // 25
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hC1, 8'h60}, // 26
        '{1'b1, 8'h33, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h33, 8'h60}, // 27 R7 byte 8
        '{1'b1, 8'h44, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 28 R7 byte 9
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h44, 8'h60}, // 29 R8 entry
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 30 byte 1
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 31
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 32
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 33
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 34
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 35
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h60}, // 36 byte 7
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h44}  // 37 R8/R6 held sample
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [7:0]        smp_data;
    logic              smp_valid, sync_hit, rx_enter, byte_stb, sync_en, append_en;
    logic [7:0]        rd_value, snap_value;
    logic signed [8:0] rd_power;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    rssi_hold uut (
        .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
        .sync_hit(sync_hit), .rx_enter(rx_enter), .byte_stb(byte_stb),
        .sync_en(sync_en), .append_en(append_en), .rd_value(rd_value),
        .snap_value(snap_value), .rd_power(rd_power)
    );

    // Expected power from the requirement text: signed reading, floor half, minus 72.
    function automatic logic signed [8:0] exp_pwr(input logic [7:0] r);
        int v;
        v = int'(r);
        if (v >= 128) v = v - 256;
        v = (v >= 0) ? v / 2 : -(((-v) + 1) / 2);
        return 9'(v - 72);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] s, input logic sy,
                         input logic rx, input logic b, input logic se, input logic ap);
        smp_valid = v; smp_data = s; sync_hit = sy; rx_enter = rx;
        byte_stb = b; sync_en = se; append_en = ap;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #800000;
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "rd_value", int'(rd_value), 0);
        check("R1", "snap_value", int'(snap_value), 0);
        check("R1", "rd_power", int'(rd_power), -72);
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].v, VECS[i].s, VECS[i].sy, VECS[i].rx,
                  VECS[i].b, VECS[i].se, VECS[i].ap);
            @(negedge clk);
            check("R2-R8 table", $sformatf("vec %0d rd_value", i), int'(rd_value), int'(VECS[i].erd));
            check("R6 table", $sformatf("vec %0d snap_value", i), int'(snap_value), int'(VECS[i].esn));
            check("R9 table", $sformatf("vec %0d rd_power", i), int'(rd_power), int'(exp_pwr(VECS[i].erd)));
        end

        // R1: reset in the middle of a held packet clears everything
        drive(1'b1, 8'h22, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R1", "rd_value after mid reset", int'(rd_value), 0);
        check("R1", "snap_value after mid reset", int'(snap_value), 0);
        rst_n = 1'b1;

        // R2: tracking resumes after reset without rx_enter
        drive(1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R2", "rd_value after reset", int'(rd_value), 127);
        // R9: largest positive reading
        check("R9", "rd_power 0x7F", int'(rd_power), -9);

        drive(1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        // R9: most negative reading
        check("R9", "rd_power 0x80", int'(rd_power), -136);

        drive(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        // R9: minus one rounds down
        check("R9", "rd_power 0xFF", int'(rd_power), -73);

        drive(1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R9", "rd_power 0x01", int'(rd_power), -72);

        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        finish_run();
    end

endmodule